// File: doc/BRIEF.md
# I2C Multi-Master Byte Transmitter with Collision Abort

This block is the transmit side of an I2C master that must share the bus with other masters. It drives the open-drain SDA and SCL wires through two pull-low enables and reads both wires back through a two-flop synchroniser. One request pulse launches one operation at a time: a Start, a Repeated Start, a Stop, an acknowledge bit, or a byte written into the transmit buffer. A byte is shifted out most significant bit first, and a ninth clock then reads the receiver's acknowledge.

Whenever the block leaves SDA released to send a one, it samples the synchronised SDA while SCL is high. If it reads a zero, another device owns the bus. The block then drops the operation in progress, releases both wires, clears the request and buffer flags, and sets a sticky collision flag that stays set until software clears it. A bus monitor keeps watching both wires at all times. It records Start and Stop conditions made by any master and derives a bus-free indication from them, so software can tell when it may try again.

Bit timing comes from a programmable divider. Each bit period is split into four quarters of `div_val + 1` clock cycles.

Top module: `i2cm_arb_master`

## Requirements
- R1: Each bit period has four quarters of `div_val + 1` clocks each. The block changes SDA for a data bit only while SCL is low, releases SCL one quarter later, samples SDA at the next quarter, and pulls SCL low again after that. SCL therefore stays high for exactly 2*(div_val+1) clocks per bit.
- R2: A write to an idle block sends the 8-bit `wr_data` MSB first, followed by a ninth clock with SDA released. The SDA level sampled in that ninth clock appears on `ack_rx`, where 0 means the receiver acknowledged.
- R3: If SDA is sampled low while SCL is high during a data bit in which the block sends a one, the block raises `bcl_flag`, returns to idle (`busy` = 0), releases SDA and SCL, and clears `buf_full`.
- R4: A collision during Start, Repeated Start, Stop or acknowledge sending aborts that operation and releases both wires. It also clears `req_pend`, whose bits are: bit0 Start, bit1 Repeated Start, bit2 Stop, bit3 acknowledge. Start checks that SDA is still high before pulling it low. Stop checks that SDA has risen after it releases SDA.
- R5: An acknowledge request drives `ack_val` for one bit. A value of 0 pulls SDA low and never collides. A value of 1 (NACK) is collision-checked in the same way as a data one.
- R6: `bcl_flag` stays set until a `bcl_clr` pulse. While it is set, `start_go` and `rstart_go` are ignored and the wires stay released.
- R7: After a collision, the next written byte is sent complete, starting from its MSB.
- R8: `bus_s` is set by SDA falling while SCL is high, and that also clears `bus_p`. `bus_p` is set by SDA rising while SCL is high, and that also clears `bus_s`. Both use the synchronised wires. `ev_flag` is set by a detected Stop or by the completion of any operation, and is cleared by `ev_clr`.
- R9: `bus_free` is high when `bus_p` is set, or when both `bus_s` and `bus_p` are clear.
- R10: `buf_full` rises when an idle block accepts a write and falls after the eighth bit has been sent. A write made while the block is busy is ignored.
- R11: A Repeated Start releases SDA, then releases SCL, then pulls SDA low while SCL is high, then pulls SCL low. It finishes with both enables asserted and `ev_flag` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_i | input | 1 | SDA wire level |
| scl_i | input | 1 | SCL wire level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_oe | output | 1 | Pull SCL low when 1 |
| div_val | input | DIV_W | Quarter-bit length minus one, in clocks |
| start_go | input | 1 | Request a Start |
| rstart_go | input | 1 | Request a Repeated Start |
| stop_go | input | 1 | Request a Stop |
| ack_go | input | 1 | Request an acknowledge bit |
| ack_val | input | 1 | Acknowledge level to send (1 = NACK) |
| wr_en | input | 1 | Write `wr_data` into the buffer and send it |
| wr_data | input | DATA_W | Byte to send |
| bcl_clr | input | 1 | Clear the collision flag |
| ev_clr | input | 1 | Clear the event flag |
| req_pend | output | 4 | Pending operation bits |
| busy | output | 1 | An operation is in progress |
| buf_full | output | 1 | Transmit buffer holds an unsent byte |
| ack_rx | output | 1 | Acknowledge level read in the ninth clock |
| bcl_flag | output | 1 | Sticky bus-collision flag |
| ev_flag | output | 1 | Sticky operation-complete / Stop-seen flag |
| bus_s | output | 1 | Start seen last on the bus |
| bus_p | output | 1 | Stop seen last on the bus |
| bus_free | output | 1 | Bus may be claimed |

## Verification
The transmitter is tried against three bus partners. The first is a passive receiver that pulls SDA low only in the ninth clock. With it, the serialised byte and the acknowledge read-back can be checked apart from any arbitration effect. The second is a competing transmitter whose byte matches ours in its first three bits and then sends a zero where ours sends a one; this shows that the abort happens at exactly the first mismatching bit and not earlier. The third is a master that holds SDA low outright during a Start, a NACK and a Stop; it separates the three condition-phase collision checks from the data-phase check. A behavioural model of the bus monitor follows every wire transition, including those made by the other devices, and is compared on every clock.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_RSTART,
    ST_STOP,
    ST_BIT,
    ST_ACKRX,
    ST_ACKTX
  } seq_st_t;

  localparam int REQ_W      = 4;
  localparam int REQ_START  = 0;
  localparam int REQ_RSTART = 1;
  localparam int REQ_STOP   = 2;
  localparam int REQ_ACK    = 3;

  localparam logic [1:0] Q0 = 2'd0;
  localparam logic [1:0] Q1 = 2'd1;
  localparam logic [1:0] Q2 = 2'd2;
  localparam logic [1:0] Q3 = 2'd3;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= '1;
          else        pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= '1;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/i2cm_qdiv.sv
module i2cm_qdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             qtick
);

  logic [DIV_W-1:0] cnt_q, cnt_n;

  assign qtick = run && (cnt_q == '0);

  always_comb begin
    if (!run || (cnt_q == '0)) cnt_n = div_val;
    else                       cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/i2cm_shifter.sv
module i2cm_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);

  logic [W-1:0] sr_q, sr_n;

  always_comb begin
    sr_n = sr_q;
    if (load)       sr_n = din;
    else if (shift) sr_n = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_n;
  end

  assign msb = sr_q[W-1];

endmodule

// File: rtl/i2cm_bus_mon.sv
module i2cm_bus_mon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_i,
  input  logic scl_i,
  output logic sda_s,
  output logic scl_s,
  output logic stop_det,
  output logic bus_s,
  output logic bus_p,
  output logic bus_free
);

  logic [1:0] raw;
  logic [1:0] synced;
  logic       sda_prev_q;
  logic       start_det;
  logic       s_n, p_n;

  assign raw = {scl_i, sda_i};

  i2cm_sync #(.W(2), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (synced)
  );

  assign sda_s = synced[0];
  assign scl_s = synced[1];

  assign start_det = scl_s &&  sda_prev_q && !sda_s;
  assign stop_det  = scl_s && !sda_prev_q &&  sda_s;

  always_comb begin
    s_n = bus_s;
    p_n = bus_p;
    if (start_det) begin
      s_n = 1'b1;
      p_n = 1'b0;
    end else if (stop_det) begin
      s_n = 1'b0;
      p_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev_q <= 1'b1;
      bus_s      <= 1'b0;
      bus_p      <= 1'b0;
    end else begin
      sda_prev_q <= sda_s;
      bus_s      <= s_n;
      bus_p      <= p_n;
    end
  end

  assign bus_free = bus_p || (!bus_s && !bus_p);

endmodule

// File: rtl/i2cm_arb_master.sv
module i2cm_arb_master
  import i2cm_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_i,
  output logic              sda_oe,
  output logic              scl_oe,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              start_go,
  input  logic              rstart_go,
  input  logic              stop_go,
  input  logic              ack_go,
  input  logic              ack_val,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bcl_clr,
  input  logic              ev_clr,
  output logic [3:0]        req_pend,
  output logic              busy,
  output logic              buf_full,
  output logic              ack_rx,
  output logic              bcl_flag,
  output logic              ev_flag,
  output logic              bus_s,
  output logic              bus_p,
  output logic              bus_free
);

  localparam int               CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  seq_st_t          st_q, st_n;
  logic [1:0]       q_q, q_n;
  logic [CNT_W-1:0] bcnt_q, bcnt_n;
  logic             sda_q, sda_n;
  logic             scl_q, scl_n;
  logic [REQ_W-1:0] req_q, req_n;
  logic             buf_q, buf_n;
  logic             ackv_q, ackv_n;
  logic             ackrx_q, ackrx_n;
  logic             bcl_q, bcl_n;
  logic             ev_q, ev_n;

  logic             sda_s, scl_s, stop_det;
  logic             qtick;
  logic             seq_run;
  logic             ld, sh, tx_msb;
  logic             coll, done;

  i2cm_bus_mon #(.STAGES(2)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_i    (sda_i),
    .scl_i    (scl_i),
    .sda_s    (sda_s),
    .scl_s    (scl_s),
    .stop_det (stop_det),
    .bus_s    (bus_s),
    .bus_p    (bus_p),
    .bus_free (bus_free)
  );

  assign seq_run = (st_q != ST_IDLE);

  i2cm_qdiv #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (seq_run),
    .div_val (div_val),
    .qtick   (qtick)
  );

  i2cm_shifter #(.W(DATA_W)) u_shf (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ld),
    .shift (sh),
    .din   (wr_data),
    .msb   (tx_msb)
  );

  // Sequencer: launch in idle, then one action per quarter tick.
  always_comb begin
    st_n    = st_q;
    q_n     = q_q;
    bcnt_n  = bcnt_q;
    sda_n   = sda_q;
    scl_n   = scl_q;
    req_n   = req_q;
    buf_n   = buf_q;
    ackv_n  = ackv_q;
    ackrx_n = ackrx_q;
    bcl_n   = bcl_q;
    ev_n    = ev_q;
    ld      = 1'b0;
    sh      = 1'b0;
    coll    = 1'b0;
    done    = 1'b0;

    if (bcl_clr)  bcl_n = 1'b0;
    if (ev_clr)   ev_n  = 1'b0;
    if (stop_det) ev_n  = 1'b1;

    if (st_q == ST_IDLE) begin
      q_n = Q0;
      if (start_go && !bcl_q) begin
        st_n             = ST_START;
        req_n[REQ_START] = 1'b1;
      end else if (rstart_go && !bcl_q) begin
        st_n              = ST_RSTART;
        req_n[REQ_RSTART] = 1'b1;
      end else if (stop_go) begin
        st_n            = ST_STOP;
        req_n[REQ_STOP] = 1'b1;
      end else if (ack_go) begin
        st_n           = ST_ACKTX;
        req_n[REQ_ACK] = 1'b1;
        ackv_n         = ack_val;
      end else if (wr_en) begin
        st_n   = ST_BIT;
        ld     = 1'b1;
        buf_n  = 1'b1;
        bcnt_n = '0;
      end
    end else if (qtick) begin
      q_n = q_q + 2'd1;
      case (st_q)
        ST_START: begin
          case (q_q)
            Q0: begin sda_n = 1'b0; scl_n = 1'b0; end
            Q1: if (scl_s && !sda_s) coll = 1'b1;
            Q2: sda_n = 1'b1;
            default: begin scl_n = 1'b1; done = 1'b1; end
          endcase
        end
        ST_RSTART: begin
          case (q_q)
            Q0: sda_n = 1'b0;
            Q1: scl_n = 1'b0;
            Q2: if (scl_s && !sda_s) coll = 1'b1;
                else                 sda_n = 1'b1;
            default: begin scl_n = 1'b1; done = 1'b1; end
          endcase
        end
        ST_STOP: begin
          case (q_q)
            Q0: begin scl_n = 1'b1; sda_n = 1'b1; end
            Q1: scl_n = 1'b0;
            Q2: sda_n = 1'b0;
            default: if (scl_s && !sda_s) coll = 1'b1;
                     else                 done = 1'b1;
          endcase
        end
        ST_BIT: begin
          case (q_q)
            Q0: begin scl_n = 1'b1; sda_n = !tx_msb; end
            Q1: scl_n = 1'b0;
            Q2: if (tx_msb && scl_s && !sda_s) coll = 1'b1;
            default: begin
              scl_n = 1'b1;
              sh    = 1'b1;
              if (bcnt_q == LAST_BIT) begin
                st_n   = ST_ACKRX;
                buf_n  = 1'b0;
                bcnt_n = '0;
              end else begin
                bcnt_n = bcnt_q + 1'b1;
              end
            end
          endcase
        end
        ST_ACKRX: begin
          case (q_q)
            Q0: begin scl_n = 1'b1; sda_n = 1'b0; end
            Q1: scl_n = 1'b0;
            Q2: ackrx_n = sda_s;
            default: begin scl_n = 1'b1; done = 1'b1; end
          endcase
        end
        ST_ACKTX: begin
          case (q_q)
            Q0: begin scl_n = 1'b1; sda_n = !ackv_q; end
            Q1: scl_n = 1'b0;
            Q2: if (ackv_q && scl_s && !sda_s) coll = 1'b1;
            default: begin scl_n = 1'b1; sda_n = 1'b0; done = 1'b1; end
          endcase
        end
        default: st_n = ST_IDLE;
      endcase
    end

    if (coll) begin
      st_n  = ST_IDLE;
      q_n   = Q0;
      sda_n = 1'b0;
      scl_n = 1'b0;
      req_n = '0;
      buf_n = 1'b0;
      bcl_n = 1'b1;
    end else if (done) begin
      st_n  = ST_IDLE;
      q_n   = Q0;
      req_n = '0;
      ev_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      q_q     <= Q0;
      bcnt_q  <= '0;
      sda_q   <= 1'b0;
      scl_q   <= 1'b0;
      req_q   <= '0;
      buf_q   <= 1'b0;
      ackv_q  <= 1'b0;
      ackrx_q <= 1'b1;
      bcl_q   <= 1'b0;
      ev_q    <= 1'b0;
    end else begin
      st_q    <= st_n;
      q_q     <= q_n;
      bcnt_q  <= bcnt_n;
      sda_q   <= sda_n;
      scl_q   <= scl_n;
      req_q   <= req_n;
      buf_q   <= buf_n;
      ackv_q  <= ackv_n;
      ackrx_q <= ackrx_n;
      bcl_q   <= bcl_n;
      ev_q    <= ev_n;
    end
  end

  assign sda_oe   = sda_q;
  assign scl_oe   = scl_q;
  assign req_pend = req_q;
  assign busy     = seq_run;
  assign buf_full = buf_q;
  assign ack_rx   = ackrx_q;
  assign bcl_flag = bcl_q;
  assign ev_flag  = ev_q;

endmodule

// File: rtl/i2cm_arb_master_chk.sv
module i2cm_arb_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       start_go,
  input logic       rstart_go,
  input logic       stop_go,
  input logic       ack_go,
  input logic       wr_en,
  input logic       bcl_clr,
  input logic [3:0] req_pend,
  input logic       busy,
  input logic       buf_full,
  input logic       bcl_flag,
  input logic       ev_flag,
  input logic       bus_p
);

  AST_COLL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcl_flag) |-> (!sda_oe && !scl_oe && !busy)); // R3

  AST_COLL_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcl_flag) |-> (req_pend == 4'b0000 && !buf_full)); // R4

  AST_PEND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_pend)); // R4

  AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (bcl_flag && !bcl_clr) |=> bcl_flag); // R6

  AST_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bcl_flag && !busy && (start_go || rstart_go) && !stop_go && !ack_go && !wr_en)
      |=> (!busy && req_pend == 4'b0000)); // R6

  AST_BUF_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> busy); // R10

  AST_STOP_RAISES_EV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_p) |-> ev_flag); // R8

endmodule

bind i2cm_arb_master i2cm_arb_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_oe    (sda_oe),
  .scl_oe    (scl_oe),
  .start_go  (start_go),
  .rstart_go (rstart_go),
  .stop_go   (stop_go),
  .ack_go    (ack_go),
  .wr_en     (wr_en),
  .bcl_clr   (bcl_clr),
  .req_pend  (req_pend),
  .busy      (busy),
  .buf_full  (buf_full),
  .bcl_flag  (bcl_flag),
  .ev_flag   (ev_flag),
  .bus_p     (bus_p)
);

// File: tb/i2cm_arb_master_tb.sv
module i2cm_arb_master_tb;

  localparam int CLK_P  = 10;
  localparam int DIV    = 4;
  localparam int HI_EXP = 2 * (DIV + 1) * CLK_P;

  logic       clk, rst_n;
  logic       sda_oe, scl_oe;
  logic       start_go, rstart_go, stop_go, ack_go, ack_val;
  logic       wr_en, bcl_clr, ev_clr;
  logic [7:0] wr_data;
  logic [3:0] req_pend;
  logic       busy, buf_full, ack_rx, bcl_flag, ev_flag;
  logic       bus_s, bus_p, bus_free;
  logic       sda_line, scl_line;

  // bus partners
  logic       opp_en, opp_hold, slv_en;
  logic [7:0] opp_byte;
  int         opp_base, slv_base, cap_base;
  int         fall_cnt, cap_n;
  logic [15:0] cap;
  time        t_rise, hi_w;
  logic       opp_low, slv_low;

  int checks, failures;

  i2cm_arb_master #(.DIV_W(8), .DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_line), .scl_i(scl_line),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .div_val(8'(DIV)),
    .start_go(start_go), .rstart_go(rstart_go), .stop_go(stop_go),
    .ack_go(ack_go), .ack_val(ack_val), .wr_en(wr_en), .wr_data(wr_data),
    .bcl_clr(bcl_clr), .ev_clr(ev_clr), .req_pend(req_pend), .busy(busy),
    .buf_full(buf_full), .ack_rx(ack_rx), .bcl_flag(bcl_flag),
    .ev_flag(ev_flag), .bus_s(bus_s), .bus_p(bus_p), .bus_free(bus_free)
  );

  assign sda_line = !(sda_oe || opp_low || slv_low || opp_hold);
  assign scl_line = !scl_oe;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = !clk;

  always @(negedge scl_line) begin
    fall_cnt = fall_cnt + 1;
    hi_w     = $time - t_rise;
  end

  always @(posedge scl_line) begin
    t_rise = $time;
    cap    = {cap[14:0], sda_line};
    cap_n  = cap_n + 1;
  end

  always_comb begin
    int oi;
    int si;
    oi = fall_cnt - opp_base;
    si = fall_cnt - slv_base;
    opp_low = 1'b0;
    if (opp_en && oi >= 0 && oi < 8) opp_low = !opp_byte[7-oi];
    slv_low = slv_en && (si == 8);
  end

  // behavioural reference for the bus monitor
  logic m_sd1, m_sd2, m_sdp, m_sc1, m_sc2;
  logic m_S, m_P;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sd1 = 1; m_sd2 = 1; m_sdp = 1; m_sc1 = 1; m_sc2 = 1;
      m_S = 0; m_P = 0;
    end else begin
      if (m_sc2 && m_sdp && !m_sd2) begin m_S = 1; m_P = 0; end
      else if (m_sc2 && !m_sdp && m_sd2) begin m_S = 0; m_P = 1; end
      m_sdp = m_sd2; m_sd2 = m_sd1; m_sd1 = sda_line;
      m_sc2 = m_sc1; m_sc1 = scl_line;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(bus_s == m_S, "R8 bus_s model", int'(bus_s), int'(m_S));
      chk(bus_p == m_P, "R8 bus_p model", int'(bus_p), int'(m_P));
      chk(bus_free == (m_P || (!m_S && !m_P)), "R9 bus_free model",
          int'(bus_free), int'(m_P || (!m_S && !m_P)));
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    while (busy && k < 4000) begin @(negedge clk); k++; end
    if (busy) chk(1'b0, "idle timeout", 1, 0);
  endtask

  task automatic go_start();  start_go  = 1; @(negedge clk); start_go  = 0; endtask
  task automatic go_rstart(); rstart_go = 1; @(negedge clk); rstart_go = 0; endtask
  task automatic go_stop();   stop_go   = 1; @(negedge clk); stop_go   = 0; endtask
  task automatic go_clr();    bcl_clr   = 1; @(negedge clk); bcl_clr   = 0; endtask
  task automatic go_evclr();  ev_clr    = 1; @(negedge clk); ev_clr    = 0; endtask
  task automatic go_ack(input logic v);
    ack_val = v; ack_go = 1; @(negedge clk); ack_go = 0;
  endtask
  task automatic go_write(input logic [7:0] d);
    wr_data = d; wr_en = 1; @(negedge clk); wr_en = 0;
  endtask

  initial begin
    checks = 0; failures = 0;
    start_go = 0; rstart_go = 0; stop_go = 0; ack_go = 0; ack_val = 0;
    wr_en = 0; wr_data = 0; bcl_clr = 0; ev_clr = 0;
    opp_en = 0; opp_hold = 0; slv_en = 0; opp_byte = 0;
    opp_base = 0; slv_base = 0; cap_base = 0;
    fall_cnt = 0; cap_n = 0; cap = 0; t_rise = 0; hi_w = 0;
    rst_n = 0;
    cyc(4);
    rst_n = 1;
    cyc(2);

    // reset state
    chk(!sda_oe && !scl_oe, "R3 reset lines released", int'({sda_oe, scl_oe}), 0);
    chk(!bcl_flag && !buf_full && !busy, "R6 reset flags", int'(bcl_flag), 0);
    chk(req_pend == 0, "R4 reset req_pend", int'(req_pend), 0);
    chk(bus_free, "R9 reset bus free", int'(bus_free), 1);

    // clean byte with receiver ack, then stop
    go_start();
    chk(req_pend == 4'b0001, "R4 start pending bit0", int'(req_pend), 1);
    wait_idle();
    chk(sda_oe && scl_oe, "R8 start holds both low", int'({sda_oe, scl_oe}), 3);
    chk(bus_s && !bus_p, "R8 start detected", int'({bus_s, bus_p}), 2);
    slv_base = fall_cnt; slv_en = 1; cap_base = cap_n;
    go_write(8'hA5);
    cyc(20);
    chk(buf_full, "R10 buf_full during byte", int'(buf_full), 1);
    go_write(8'h3C);
    wait_idle();
    chk(cap_n - cap_base == 9, "R2 nine clocks", cap_n - cap_base, 9);
    chk(cap[8:0] == {8'hA5, 1'b0}, "R2 byte MSB first (R10 late write ignored)",
        int'(cap[8:0]), int'({8'hA5, 1'b0}));
    chk(ack_rx == 1'b0, "R2 ack read", int'(ack_rx), 0);
    chk(!buf_full, "R10 buf_full cleared", int'(buf_full), 0);
    chk(hi_w == HI_EXP, "R1 SCL high width", int'(hi_w), HI_EXP);
    slv_en = 0;
    go_evclr();
    go_stop();
    wait_idle();
    chk(!sda_oe && !scl_oe, "R8 stop releases", int'({sda_oe, scl_oe}), 0);
    chk(bus_p && !bus_s, "R8 stop detected", int'({bus_s, bus_p}), 1);
    chk(ev_flag, "R8 ev_flag after stop", int'(ev_flag), 1);
    chk(bus_free, "R9 free after stop", int'(bus_free), 1);

    // lost arbitration in the fourth data bit
    go_evclr();
    go_start();
    wait_idle();
    opp_byte = 8'hE0; opp_base = fall_cnt; opp_en = 1; cap_base = cap_n;
    go_write(8'hF0);
    wait_idle();
    chk(bcl_flag, "R3 collision flagged", int'(bcl_flag), 1);
    chk(!sda_oe && !scl_oe, "R3 lines released", int'({sda_oe, scl_oe}), 0);
    chk(!buf_full, "R3 buf_full cleared", int'(buf_full), 0);
    chk(cap_n - cap_base == 4, "R3 abort at first mismatch", cap_n - cap_base, 4);
    chk(cap[3:0] == 4'b1110, "R3 bus bits", int'(cap[3:0]), 14);
    go_evclr();
    opp_en = 0;
    cyc(6);
    chk(bus_p && ev_flag, "R8 other master stop seen", int'({bus_p, ev_flag}), 3);

    // start ignored while flag set
    go_start();
    cyc(10);
    chk(!busy && !sda_oe && req_pend == 0, "R6 start ignored", int'(busy), 0);
    go_rstart();
    cyc(10);
    chk(!busy && !sda_oe, "R6 rstart ignored", int'(busy), 0);
    chk(bcl_flag, "R6 flag sticky", int'(bcl_flag), 1);
    go_clr();
    chk(!bcl_flag, "R6 flag cleared", int'(bcl_flag), 0);

    // full byte after the collision, then repeated start
    go_start();
    wait_idle();
    slv_base = fall_cnt; slv_en = 1; cap_base = cap_n;
    go_write(8'h81);
    wait_idle();
    chk(cap_n - cap_base == 9 && cap[8:0] == {8'h81, 1'b0}, "R7 restart from MSB",
        int'(cap[8:0]), int'({8'h81, 1'b0}));
    slv_en = 0;
    go_evclr();
    go_rstart();
    chk(req_pend == 4'b0010, "R11 rstart pending bit1", int'(req_pend), 2);
    wait_idle();
    chk(sda_oe && scl_oe && ev_flag && req_pend == 0, "R11 rstart completes",
        int'({sda_oe, scl_oe, ev_flag}), 7);
    chk(bus_s && !bus_p, "R11 start condition seen", int'({bus_s, bus_p}), 2);
    go_stop();
    wait_idle();

    // collision during start
    opp_hold = 1;
    cyc(6);
    chk(!bus_free, "R9 busy bus after foreign start", int'(bus_free), 0);
    go_start();
    wait_idle();
    chk(bcl_flag && req_pend == 0, "R4 start collision", int'(bcl_flag), 1);
    chk(!sda_oe && !scl_oe, "R4 start abort releases", int'({sda_oe, scl_oe}), 0);
    opp_hold = 0;
    cyc(6);
    chk(bus_free && bus_p, "R9 free after foreign stop", int'(bus_free), 1);
    go_clr();

    // acknowledge: ACK never collides, NACK does
    go_start();
    wait_idle();
    go_ack(1'b0);
    chk(req_pend == 4'b1000, "R4 ack pending bit3", int'(req_pend), 8);
    opp_hold = 1;
    wait_idle();
    opp_hold = 0;
    chk(!bcl_flag && scl_oe, "R5 ack low no collision", int'(bcl_flag), 0);
    opp_hold = 1;
    go_ack(1'b1);
    wait_idle();
    chk(bcl_flag && req_pend == 0, "R5 NACK collision", int'(bcl_flag), 1);
    chk(!sda_oe && !scl_oe, "R4 ack abort releases", int'({sda_oe, scl_oe}), 0);
    opp_hold = 0;
    cyc(6);
    go_clr();

    // collision during stop
    go_start();
    wait_idle();
    opp_hold = 1;
    go_stop();
    chk(req_pend == 4'b0100, "R4 stop pending bit2", int'(req_pend), 4);
    wait_idle();
    chk(bcl_flag && req_pend == 0, "R4 stop collision", int'(bcl_flag), 1);
    chk(!sda_oe && !scl_oe, "R4 stop abort releases", int'({sda_oe, scl_oe}), 0);
    opp_hold = 0;
    cyc(6);
    go_clr();
    cyc(4);

    finish_run();
  end

endmodule